// File: doc/BRIEF.md
# Subranging Conversion Sequencer

This block runs a two-pass, feed-forward analog-to-digital conversion that uses two flash converters and produces a 12-bit result. A start pulse begins the sequence. The block first lets the held input settle into the coarse flash converter and reads its 6-bit code. It then sends that code to an external DAC, whose output is subtracted from the held input. The difference is amplified and presented to a second flash converter that is wired for 7 bits. After a programmable settling time, the block reads that 7-bit fine code. It then merges the two codes into one word and flags a result that had to be clamped.

The fine converter only measures positive residues. For this reason the coarse code is reduced by one coarse step before the merge. The merge places the lowest coarse bit on top of the highest fine bit, so the two words share one bit. The fine converter's overflow line acts as an extra fine count worth 128, which lets the merged sum rise one step above the 12-bit range. The hold-control output keeps the external sample-and-hold in hold mode for the whole measurement.

The controller has five states.
- SEQ_IDLE waits for start. On start it loads the wait counts and moves to SEQ_COARSE.
- SEQ_COARSE counts the capture wait. At the end it captures the coarse code, pulses the DAC load and moves to SEQ_SETTLE.
- SEQ_SETTLE counts the DAC settle time and then moves to SEQ_FINE.
- SEQ_FINE counts the capture wait again. At the end it captures the fine code and moves to SEQ_COMBINE.
- SEQ_COMBINE registers the corrected result with a done pulse and returns to SEQ_IDLE.

Top module: `subrange_seq`

## Requirements
- R1: While rst_n is low, and after its release until the first start, hold_o, dac_load_o, done_o, out_of_range_o, dac_code_o and result_o are all zero.
- R2: The posedge that samples start_i in SEQ_IDLE is edge 0. The coarse code is captured on edge C+1, where C is capture_wait_i. dac_load_o is high during the following cycle. done_o rises on edge 2C+S+4, where S is settle_wait_i.
- R3: hold_o is high from edge 0 until edge 2C+S+3, which is the fine capture, for 2C+S+3 cycles in total. It is low in SEQ_COMBINE and in SEQ_IDLE.
- R4: dac_code_o holds the coarse code captured on edge C+1. dac_load_o is a single-cycle pulse. Changes on coarse_code_i after the capture do not affect dac_code_o or result_o.
- R5: For a coarse code k with 1 ≤ k ≤ 63 and a fine value f, the result is (k − 1)·64 + f.
- R6: The fine value f is fine_code_i, or 128 when fine_ovf_i is high at capture. A sum above 4095 gives result 4095 with out_of_range_o high. An in-range sum gives out_of_range_o low.
- R7: A coarse code of zero gives result 0 with out_of_range_o high, whatever the fine code.
- R8: A start pulse while the sequencer is outside SEQ_IDLE is ignored. It produces no extra done pulse, and the timing of the running conversion does not change.
- R9: capture_wait_i and settle_wait_i are sampled only on the edge that accepts a start. Changing them during a conversion does not change its timing.
- R10: done_o is high for exactly one cycle per conversion. result_o and out_of_range_o change only on the edge that raises done_o and hold their value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled in SEQ_IDLE |
| capture_wait_i | input | CNT_W | Extra cycles before each flash capture |
| settle_wait_i | input | CNT_W | Extra cycles for DAC settling |
| coarse_code_i | input | COARSE_W | Coarse flash converter code |
| fine_code_i | input | COARSE_W+1 | Fine flash converter code |
| fine_ovf_i | input | 1 | Fine converter overflow, counts as 2^(COARSE_W+1) |
| dac_code_o | output | COARSE_W | Code driven to the external DAC |
| dac_load_o | output | 1 | One-cycle DAC load strobe |
| hold_o | output | 1 | Sample-and-hold in hold mode |
| result_o | output | 2*COARSE_W | Corrected, clamped conversion result |
| done_o | output | 1 | One-cycle result-valid pulse |
| out_of_range_o | output | 1 | Result was clamped |

## Verification
The bench builds the block with COARSE_W at 6 and CNT_W at 4. This keeps the result at the 12-bit target and limits each wait count to 0..15. With those values the bench can reach the shortest sequence (both waits zero) and the longest one (both waits at 15) in a few dozen cycles each. The 6-bit codes also let the bench hit the clamp corners directly: a coarse code of zero, a coarse code of 63 with fine overflow, and the exact in-range ceiling of 4095.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_COARSE,
        SEQ_SETTLE,
        SEQ_FINE,
        SEQ_COMBINE
    } seq_state_e;

    // Which value the wait counter is loaded with
    typedef enum logic [1:0] {
        LD_CAP_LIVE,
        LD_SETTLE,
        LD_CAP_HELD
    } wait_sel_e;

endpackage

// File: rtl/subrange_timer.sv
module subrange_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/subrange_ctrl.sv
module subrange_ctrl
    import subrange_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      tmr_zero_i,
    output logic      tmr_load_o,
    output wait_sel_e tmr_sel_o,
    output logic      accept_o,
    output logic      cap_coarse_o,
    output logic      cap_fine_o,
    output logic      finish_o,
    output logic      hold_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:    if (start_i)    state_d = SEQ_COARSE;
            SEQ_COARSE:  if (tmr_zero_i) state_d = SEQ_SETTLE;
            SEQ_SETTLE:  if (tmr_zero_i) state_d = SEQ_FINE;
            SEQ_FINE:    if (tmr_zero_i) state_d = SEQ_COMBINE;
            SEQ_COMBINE: state_d = SEQ_IDLE;
            default:     state_d = SEQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tmr_load_o   = 1'b0;
        tmr_sel_o    = LD_CAP_LIVE;
        accept_o     = 1'b0;
        cap_coarse_o = 1'b0;
        cap_fine_o   = 1'b0;
        finish_o     = 1'b0;
        hold_o       = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    tmr_load_o = 1'b1;
                    tmr_sel_o  = LD_CAP_LIVE;
                    accept_o   = 1'b1;
                end
            end
            SEQ_COARSE: begin
                hold_o = 1'b1;
                if (tmr_zero_i) begin
                    tmr_load_o   = 1'b1;
                    tmr_sel_o    = LD_SETTLE;
                    cap_coarse_o = 1'b1;
                end
            end
            SEQ_SETTLE: begin
                hold_o = 1'b1;
                if (tmr_zero_i) begin
                    tmr_load_o = 1'b1;
                    tmr_sel_o  = LD_CAP_HELD;
                end
            end
            SEQ_FINE: begin
                hold_o = 1'b1;
                if (tmr_zero_i) begin
                    cap_fine_o = 1'b1;
                end
            end
            SEQ_COMBINE: begin
                finish_o = 1'b1;
            end
            default: begin
                finish_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/subrange_correct.sv
module subrange_correct #(
    parameter int CW = 6,
    parameter int FW = 7,
    parameter int RW = 12
) (
    input  logic [CW-1:0] coarse_i,
    input  logic [FW-1:0] fine_i,
    input  logic          fine_ovf_i,
    output logic [RW-1:0] value_o,
    output logic          clamp_o
);

    localparam int SUM_W = RW + 2;
    localparam int SHIFT = FW - 1;
    localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((64'd1 << RW) - 64'd1);

    logic signed [SUM_W-1:0] coarse_s;
    logic signed [SUM_W-1:0] biased_s;
    logic signed [SUM_W-1:0] fine_s;
    logic signed [SUM_W-1:0] sum_s;

    always_comb begin
        coarse_s = SUM_W'(coarse_i);
        biased_s = (coarse_s - SUM_W'(1)) <<< SHIFT;
        fine_s   = fine_ovf_i ? (SUM_W'(1) <<< FW) : SUM_W'(fine_i);
        sum_s    = biased_s + fine_s;
        if (coarse_i == '0 || sum_s[SUM_W-1]) begin
            value_o = '0;
            clamp_o = 1'b1;
        end else if (sum_s > MAX_S) begin
            value_o = '1;
            clamp_o = 1'b1;
        end else begin
            value_o = sum_s[RW-1:0];
            clamp_o = 1'b0;
        end
    end

endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
    import subrange_pkg::*;
#(
    parameter int COARSE_W = 6,
    parameter int CNT_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [CNT_W-1:0]      capture_wait_i,
    input  logic [CNT_W-1:0]      settle_wait_i,
    input  logic [COARSE_W-1:0]   coarse_code_i,
    input  logic [COARSE_W:0]     fine_code_i,
    input  logic                  fine_ovf_i,
    output logic [COARSE_W-1:0]   dac_code_o,
    output logic                  dac_load_o,
    output logic                  hold_o,
    output logic [2*COARSE_W-1:0] result_o,
    output logic                  done_o,
    output logic                  out_of_range_o
);

    localparam int FINE_W = COARSE_W + 1;
    localparam int RES_W  = 2 * COARSE_W;

    logic             tmr_load;
    logic             tmr_zero;
    wait_sel_e        tmr_sel;
    logic [CNT_W-1:0] tmr_val;
    logic             accept;
    logic             cap_coarse;
    logic             cap_fine;
    logic             finish;

    logic [CNT_W-1:0]    cap_wait_q;
    logic [CNT_W-1:0]    settle_wait_q;
    logic [COARSE_W-1:0] coarse_q;
    logic [FINE_W-1:0]   fine_q;
    logic                fine_ovf_q;
    logic                dac_load_q;
    logic [RES_W-1:0]    result_q;
    logic                oor_q;
    logic                done_q;
    logic [RES_W-1:0]    corr_val;
    logic                corr_clamp;

    subrange_ctrl ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .tmr_zero_i   (tmr_zero),
        .tmr_load_o   (tmr_load),
        .tmr_sel_o    (tmr_sel),
        .accept_o     (accept),
        .cap_coarse_o (cap_coarse),
        .cap_fine_o   (cap_fine),
        .finish_o     (finish),
        .hold_o       (hold_o)
    );

    always_comb begin
        unique case (tmr_sel)
            LD_CAP_LIVE: tmr_val = capture_wait_i;
            LD_SETTLE:   tmr_val = settle_wait_q;
            LD_CAP_HELD: tmr_val = cap_wait_q;
            default:     tmr_val = cap_wait_q;
        endcase
    end

    subrange_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    subrange_correct #(.CW(COARSE_W), .FW(FINE_W), .RW(RES_W)) correct_i (
        .coarse_i   (coarse_q),
        .fine_i     (fine_q),
        .fine_ovf_i (fine_ovf_q),
        .value_o    (corr_val),
        .clamp_o    (corr_clamp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_wait_q    <= '0;
            settle_wait_q <= '0;
            coarse_q      <= '0;
            fine_q        <= '0;
            fine_ovf_q    <= 1'b0;
            dac_load_q    <= 1'b0;
            result_q      <= '0;
            oor_q         <= 1'b0;
            done_q        <= 1'b0;
        end else begin
            dac_load_q <= cap_coarse;
            done_q     <= finish;
            if (accept) begin
                cap_wait_q    <= capture_wait_i;
                settle_wait_q <= settle_wait_i;
            end
            if (cap_coarse) begin
                coarse_q <= coarse_code_i;
            end
            if (cap_fine) begin
                fine_q     <= fine_code_i;
                fine_ovf_q <= fine_ovf_i;
            end
            if (finish) begin
                result_q <= corr_val;
                oor_q    <= corr_clamp;
            end
        end
    end

    assign dac_code_o     = coarse_q;
    assign dac_load_o     = dac_load_q;
    assign result_o       = result_q;
    assign out_of_range_o = oor_q;
    assign done_o         = done_q;

endmodule

// File: rtl/subrange_seq_chk.sv
module subrange_seq_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             hold_o,
    input logic             dac_load_o,
    input logic             done_o,
    input logic [RES_W-1:0] result_o,
    input logic             out_of_range_o
);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(out_of_range_o)));

    // R3
    hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(start_i));

    // R3
    done_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !hold_o);

    // R4
    dac_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load_o |-> (hold_o && !done_o));

    // R4
    dac_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load_o |=> !dac_load_o);

    // R6
    clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && out_of_range_o) |-> (result_o == '0 || result_o == '1));

endmodule

bind subrange_seq subrange_seq_chk #(.RES_W(RES_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .hold_o         (hold_o),
    .dac_load_o     (dac_load_o),
    .done_o         (done_o),
    .result_o       (result_o),
    .out_of_range_o (out_of_range_o)
);

// File: tb/subrange_seq_tb_top.sv
`timescale 1ns/1ps
module subrange_seq_tb_top;

    localparam int CW    = 6;
    localparam int FW    = CW + 1;
    localparam int RW    = 2 * CW;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] capture_wait = '0;
    logic [CNT_W-1:0] settle_wait = '0;
    logic [CW-1:0]    coarse_code = '0;
    logic [FW-1:0]    fine_code = '0;
    logic             fine_ovf = 1'b0;
    logic [CW-1:0]    dac_code;
    logic             dac_load;
    logic             hold;
    logic [RW-1:0]    result;
    logic             done;
    logic             oor;

    subrange_seq #(.COARSE_W(CW), .CNT_W(CNT_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .capture_wait_i (capture_wait),
        .settle_wait_i  (settle_wait),
        .coarse_code_i  (coarse_code),
        .fine_code_i    (fine_code),
        .fine_ovf_i     (fine_ovf),
        .dac_code_o     (dac_code),
        .dac_load_o     (dac_load),
        .hold_o         (hold),
        .result_o       (result),
        .done_o         (done),
        .out_of_range_o (oor)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    res;
        bit    oor;
        int    coarse;
        int    done_cyc;
        int    dac_cyc;
        int    hold_len;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    cyc = 0;
    int    errors = 0;
    int    checks = 0;
    int    done_seen = 0;
    int    convs = 0;
    int    hold_cnt = 0;
    int    last_res = 0;
    bit    last_oor = 1'b0;
    bit    prev_done = 1'b0;
    bit    finished = 1'b0;
    item_t mon_it;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold) hold_cnt++;
            if (dac_load && exp_q.size() > 0) begin
                chk(int'(dac_code) == exp_q[0].coarse, "R4 dac code", int'(dac_code), exp_q[0].coarse);
                chk(cyc == exp_q[0].dac_cyc, "R2 coarse capture cycle", cyc, exp_q[0].dac_cyc);
            end
            if (done) begin
                done_seen++;
                chk(!prev_done, "R10 done width", 2, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    mon_it = exp_q.pop_front();
                    chk(int'(result) == mon_it.res, mon_it.tag, int'(result), mon_it.res);
                    chk(oor == mon_it.oor, {mon_it.tag, " flag"}, int'(oor), int'(mon_it.oor));
                    chk(cyc == mon_it.done_cyc, "R2 done cycle", cyc, mon_it.done_cyc);
                    chk(hold_cnt == mon_it.hold_len, "R3 hold length", hold_cnt, mon_it.hold_len);
                end
                hold_cnt = 0;
            end else begin
                if (int'(result) != last_res || oor != last_oor)
                    chk(1'b0, "R10 result moved without done", int'(result), last_res);
            end
            last_res  = int'(result);
            last_oor  = oor;
            prev_done = done;
        end
    end

    function automatic void expect_val(input int c, input int f, input bit fo,
                                       output int r, output bit o);
        int fv;
        int raw;
        fv = fo ? (1 << FW) : f;
        raw = (c - 1) * (1 << (FW - 1)) + fv;
        if (c == 0 || raw < 0) begin
            r = 0; o = 1'b1;
        end else if (raw > (1 << RW) - 1) begin
            r = (1 << RW) - 1; o = 1'b1;
        end else begin
            r = raw; o = 1'b0;
        end
    endfunction

    task automatic convert(input int c, input int f, input bit fo, input int capw,
                           input int setw, input bit scramble, input bit extra_start,
                           input bit cfg_change, input string tag);
        item_t it;
        expect_val(c, f, fo, it.res, it.oor);
        @(negedge clk);
        coarse_code  = CW'(c);
        fine_code    = FW'(f);
        fine_ovf     = fo;
        capture_wait = CNT_W'(capw);
        settle_wait  = CNT_W'(setw);
        start        = 1'b1;
        it.coarse    = c;
        it.done_cyc  = cyc + 2 * capw + setw + 5;
        it.dac_cyc   = cyc + capw + 2;
        it.hold_len  = 2 * capw + setw + 3;
        it.tag       = tag;
        exp_q.push_back(it);
        convs++;
        @(negedge clk);
        start = 1'b0;
        if (cfg_change) begin
            capture_wait = ~CNT_W'(capw);
            settle_wait  = ~CNT_W'(setw);
        end
        while (!dac_load) @(negedge clk);
        if (scramble) coarse_code = ~CW'(c);
        if (extra_start) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(hold == 1'b0, "R1 hold", int'(hold), 0);
        chk(dac_load == 1'b0, "R1 dac_load", int'(dac_load), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(oor == 1'b0, "R1 flag", int'(oor), 0);
        chk(int'(result) == 0 && int'(dac_code) == 0, "R1 result and dac", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(hold == 1'b0 && done == 1'b0, "R1 idle after release", int'(hold), 0);

        convert(1, 0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0, "R5 minimum counts");
        convert(32, 64, 1'b0, 2, 5, 1'b0, 1'b0, 1'b0, "R5 midscale");
        convert(63, 127, 1'b0, 15, 15, 1'b0, 1'b0, 1'b0, "R5 top in range");
        convert(40, 0, 1'b1, 3, 1, 1'b0, 1'b0, 1'b0, "R6 fine overflow in range");
        convert(63, 0, 1'b1, 1, 3, 1'b0, 1'b0, 1'b0, "R6 clamp high");
        convert(63, 127, 1'b1, 0, 2, 1'b0, 1'b0, 1'b0, "R6 clamp high overflow");
        convert(0, 100, 1'b0, 2, 2, 1'b0, 1'b0, 1'b0, "R7 zero coarse");
        convert(0, 0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0, "R7 zero coarse zero fine");
        convert(17, 5, 1'b0, 4, 6, 1'b1, 1'b0, 1'b0, "R4 coarse scrambled after capture");
        convert(9, 33, 1'b0, 3, 9, 1'b0, 1'b1, 1'b0, "R8 start while busy");
        convert(50, 90, 1'b0, 2, 3, 1'b0, 1'b0, 1'b1, "R9 config changed mid run");
        convert(2, 1, 1'b0, 1, 0, 1'b0, 1'b0, 1'b0, "R5 low codes");

        repeat (40) @(negedge clk);
        // R8: no done beyond one per accepted start
        chk(done_seen == convs, "R8 done count", done_seen, convs);
        chk(exp_q.size() == 0, "R8 pending items", exp_q.size(), 0);
        chk(hold == 1'b0, "R3 hold low when idle", int'(hold), 0);
        finish_run();
    end

endmodule